// File: doc/BRIEF.md
# Block Write-Protection Controller

This block holds the write-protection state of a serial EEPROM whose array is split into four equal protection blocks over two 256-byte pages. A block is selected by the page bit together with the most significant address bit. Upstream logic hands the controller commands that are already decoded: protect one block, unprotect every block, or report the state of one block. Every memory write the bus front end wants to perform is also offered to the controller. The controller either passes the write on or rejects it with an error pulse.

Protecting or unprotecting stands in for a nonvolatile programming operation. Each one starts a self-timed write cycle of `TW` clock cycles, and the `busy` pin is high for that whole time. While `busy` is high, both request channels apply back-pressure: `cmd_ready` and `wr_ready` are low. A requester must keep `*_valid` and its payload steady until it sees ready high at a clock edge. A transfer happens on every edge where valid and ready are both high.

The protection bits are nonvolatile. The functional reset does not touch them. Only the separate power-on load input can set them.

Top module: `wprot_ctrl`

## Requirements
- R1: The block index of a write is {page, addr MSB}. Block 0 is page 0 addresses 0x00-0x7F, block 1 is page 0 addresses 0x80-0xFF, block 2 is page 1 addresses 0x00-0x7F, and block 3 is page 1 addresses 0x80-0xFF.
- R2: An accepted command with opcode 01 sets the protection bit of the block named on `cmd_blk` and leaves the other three bits unchanged.
- R3: An accepted command with opcode 10 clears all four protection bits at once, whatever `cmd_blk` holds.
- R4: An accepted command with opcode 11 raises `sts_valid` for one cycle on the following cycle, with `sts_prot` equal to the protection bit of the named block. Opcode 00 is accepted and has no effect.
- R5: An accepted opcode 01 or 10 drives `busy` high from the next cycle for exactly `TW` consecutive cycles.
- R6: While `busy` is high, `cmd_ready` and `wr_ready` are low. A held request waits and is taken once `busy` drops. No status or write response appears for a request that was not taken.
- R7: A functional reset (`rst_n` low) leaves the protection bits unchanged. It clears `busy`, `sts_valid`, `wr_pass` and `wr_err`, and it holds both ready outputs low.
- R8: When `pwr_load` is high at an edge, the four bits take `pwr_bits` (bit n belongs to block n). This happens in reset as well, and it takes priority over a command in the same cycle.
- R9: One cycle after a write is accepted, exactly one of `wr_pass` (target block unprotected) or `wr_err` (target block protected) is high, for one cycle.
- R10: A write accepted in the same cycle as a set or clear command is judged against the protection bits as they were before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous functional reset, active low |
| pwr_load | input | 1 | Power-on load strobe for the protection bits |
| pwr_bits | input | 4 | Protection values loaded by `pwr_load`, bit n = block n |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken (low while busy or in reset) |
| cmd_op | input | 2 | 00 none, 01 set one, 10 clear all, 11 read status |
| cmd_blk | input | 2 | Block named by the command |
| sts_valid | output | 1 | One-cycle status answer strobe |
| sts_prot | output | 1 | Protection bit of the block that was asked about |
| wr_valid | input | 1 | Memory write request |
| wr_ready | output | 1 | Write can be judged (low while busy or in reset) |
| wr_page | input | 1 | Page bit of the write |
| wr_addr | input | AW (8) | Byte address of the write |
| wr_pass | output | 1 | One-cycle pulse: write allowed |
| wr_err | output | 1 | One-cycle pulse: write rejected, block protected |
| busy | output | 1 | Nonvolatile write cycle in progress |

## Verification
The assertions check on every cycle the local cause-and-effect relations. A set changes only its own bit, a clear zeroes all four bits, a status answer reflects the bit at the time the question was taken, and every accepted write gets exactly one verdict. They also check the busy window length, the absence of responses during busy, the power-on load, and the fact that reset leaves the bits alone. Only the bench scenarios can show the end-to-end orderings. These are requests stalled behind busy and taken afterwards, a write racing a set in the same cycle, a reset cutting a write cycle short, and the block mapping of all four address regions as seen through writes and status reads.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int NBLK = 4;
  localparam int BW   = $clog2(NBLK);

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_STAT = 2'b11
  } wp_op_e;
endpackage

// File: rtl/wprot_timer.sv
module wprot_timer #(
  parameter int TW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(TW + 1);
  localparam logic [CW-1:0] LOADV = CW'(TW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= LOADV;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/wprot_map.sv
module wprot_map
  import wprot_pkg::*;
(
  input  logic            clk,
  input  logic            load,
  input  logic [NBLK-1:0] load_bits,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [BW-1:0]   sel,
  output logic [NBLK-1:0] prot
);
  // No functional reset: these bits model nonvolatile cells.
  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (load)                                bit_q <= load_bits[b];
      else if (clr_en)                         bit_q <= 1'b0;
      else if (set_en && (sel == BW'(b)))      bit_q <= 1'b1;
    end
    assign prot[b] = bit_q;
  end
endmodule

// File: rtl/wprot_resp.sv
module wprot_resp
  import wprot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBLK-1:0] prot,
  input  logic            stat_fire,
  input  logic [BW-1:0]   stat_blk,
  input  logic            wr_fire,
  input  logic [BW-1:0]   wr_blk,
  output logic            sts_valid,
  output logic            sts_prot,
  output logic            wr_pass,
  output logic            wr_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_valid <= 1'b0;
      sts_prot  <= 1'b0;
      wr_pass   <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      sts_valid <= stat_fire;
      sts_prot  <= stat_fire ? prot[stat_blk] : 1'b0;
      wr_pass   <= wr_fire && !prot[wr_blk];
      wr_err    <= wr_fire &&  prot[wr_blk];
    end
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int TW = 64,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_load,
  input  logic [NBLK-1:0] pwr_bits,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [BW-1:0]   cmd_blk,
  output logic            sts_valid,
  output logic            sts_prot,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic            wr_page,
  input  logic [AW-1:0]   wr_addr,
  output logic            wr_pass,
  output logic            wr_err,
  output logic            busy
);
  wp_op_e          op;
  logic            cmd_fire, wr_fire;
  logic            set_en, clr_en, stat_fire;
  logic [BW-1:0]   wr_blk;
  logic [NBLK-1:0] prot_q;
  logic            unused_addr_lo;

  assign op        = wp_op_e'(cmd_op);
  assign cmd_ready = rst_n && !busy;
  assign wr_ready  = rst_n && !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign wr_fire   = wr_valid && wr_ready;
  assign set_en    = cmd_fire && (op == OP_SET);
  assign clr_en    = cmd_fire && (op == OP_CLR);
  assign stat_fire = cmd_fire && (op == OP_STAT);

  // Page bit selects the upper pair of blocks, address MSB the half page.
  assign wr_blk         = {wr_page, wr_addr[AW-1]};
  assign unused_addr_lo = ^wr_addr[AW-2:0];

  wprot_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (set_en || clr_en),
    .busy  (busy)
  );

  wprot_map u_map (
    .clk       (clk),
    .load      (pwr_load),
    .load_bits (pwr_bits),
    .set_en    (set_en),
    .clr_en    (clr_en),
    .sel       (cmd_blk),
    .prot      (prot_q)
  );

  wprot_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot      (prot_q),
    .stat_fire (stat_fire),
    .stat_blk  (cmd_blk),
    .wr_fire   (wr_fire),
    .wr_blk    (wr_blk),
    .sts_valid (sts_valid),
    .sts_prot  (sts_prot),
    .wr_pass   (wr_pass),
    .wr_err    (wr_err)
  );
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
  parameter int TW = 64,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_load,
  input logic [3:0]    pwr_bits,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [1:0]    cmd_blk,
  input logic          sts_valid,
  input logic          sts_prot,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_page,
  input logic [AW-1:0] wr_addr,
  input logic          wr_pass,
  input logic          wr_err,
  input logic          busy,
  input logic [3:0]    prot_q
);
  logic c_set, c_clr, c_stat, w_acc;
  logic [1:0] w_blk;
  int unsigned run_len;

  assign c_set  = cmd_valid && cmd_ready && (cmd_op == 2'b01);
  assign c_clr  = cmd_valid && cmd_ready && (cmd_op == 2'b10);
  assign c_stat = cmd_valid && cmd_ready && (cmd_op == 2'b11);
  assign w_acc  = wr_valid && wr_ready;
  assign w_blk  = {wr_page, wr_addr[AW-1]};

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_set_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_set && !pwr_load) |=> prot_q == ($past(prot_q) | (4'b0001 << $past(cmd_blk))));

  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr && !pwr_load) |=> prot_q == 4'b0000);

  assert_status_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_stat |=> (sts_valid && sts_prot == $past(prot_q[cmd_blk])));

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_set || c_clr) |=> busy);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run_len) == TW - 1));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < TW);

  assert_quiet_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!sts_valid && !wr_pass && !wr_err));

  assert_reset_keeps_R7: assert property (@(posedge clk)
    (!rst_n && !pwr_load) |=> $stable(prot_q));

  assert_power_load_R8: assert property (@(posedge clk)
    pwr_load |=> prot_q == $past(pwr_bits));

  assert_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w_acc |=> (wr_err == $past(prot_q[w_blk]) && wr_pass == !$past(prot_q[w_blk])));

  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pass, wr_err}));
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.TW(TW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_load(pwr_load), .pwr_bits(pwr_bits),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
  .sts_valid(sts_valid), .sts_prot(sts_prot), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_page(wr_page), .wr_addr(wr_addr), .wr_pass(wr_pass), .wr_err(wr_err),
  .busy(busy), .prot_q(prot_q)
);

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
  localparam int TWB = 16;

  logic clk = 1'b0;
  logic rst_n, pwr_load, cmd_valid, wr_valid, wr_page;
  logic [3:0] pwr_bits;
  logic [1:0] cmd_op, cmd_blk;
  logic [7:0] wr_addr;
  logic cmd_ready, sts_valid, sts_prot, wr_ready, wr_pass, wr_err, busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit started = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit [3:0] m_prot = 4'b0000;
  bit e_sv = 0, e_sp = 0, e_pass = 0, e_err = 0;

  always #2 clk = ~clk;   // 250 MHz

  wprot_ctrl #(.TW(TWB), .AW(8)) u_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_load(pwr_load), .pwr_bits(pwr_bits),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .sts_valid(sts_valid), .sts_prot(sts_prot), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_page(wr_page), .wr_addr(wr_addr), .wr_pass(wr_pass), .wr_err(wr_err), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model, updated at each edge from the inputs
  always @(posedge clk) begin
    bit cacc, wacc;
    int wb;
    cycles++;
    started = 1;
    if (!rst_n) begin
      m_cnt = 0; e_sv = 0; e_sp = 0; e_pass = 0; e_err = 0;
      if (pwr_load) m_prot = pwr_bits;
    end else begin
      cacc = cmd_valid && (m_cnt == 0);
      wacc = wr_valid && (m_cnt == 0);
      wb = {wr_page, wr_addr[7]};
      e_sv = cacc && cmd_op == 2'b11;
      e_sp = e_sv ? m_prot[cmd_blk] : 1'b0;
      e_pass = wacc && !m_prot[wb];
      e_err  = wacc &&  m_prot[wb];
      if (m_cnt > 0) m_cnt--;
      if (cacc && (cmd_op == 2'b01 || cmd_op == 2'b10)) m_cnt = TWB;
      if (pwr_load) m_prot = pwr_bits;
      else if (cacc && cmd_op == 2'b10) m_prot = 4'b0000;
      else if (cacc && cmd_op == 2'b01) m_prot[cmd_blk] = 1'b1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(busy == (m_cnt != 0), "R5 busy", busy, m_cnt != 0);
      check(cmd_ready == (rst_n && m_cnt == 0), "R6 cmd_ready", cmd_ready, rst_n && m_cnt == 0);
      check(wr_ready == (rst_n && m_cnt == 0), "R6 wr_ready", wr_ready, rst_n && m_cnt == 0);
      check(sts_valid == e_sv, "R4 sts_valid", sts_valid, e_sv);
      if (e_sv) check(sts_prot == e_sp, "R4 sts_prot", sts_prot, e_sp);
      check(wr_pass == e_pass, "R9 wr_pass", wr_pass, e_pass);
      check(wr_err == e_err, "R9 wr_err", wr_err, e_err);
    end
  end

  // issue a command, wait for acceptance; returns at the response negedge
  task automatic do_cmd(input logic [1:0] op, input logic [1:0] blk, output int stalls);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_blk = blk; stalls = 0;
    while (!cmd_ready) begin @(negedge clk); stalls++; end
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b00;
  endtask

  task automatic ask(input logic [1:0] blk, input bit exp, input string tag);
    int st;
    do_cmd(2'b11, blk, st);
    check(sts_valid == 1'b1, tag, sts_valid, 1);
    check(sts_prot == exp, tag, sts_prot, exp);
  endtask

  task automatic do_wr(input bit pg, input logic [7:0] a, input bit exp_err, input string tag);
    @(negedge clk);
    wr_valid = 1; wr_page = pg; wr_addr = a;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
    check(wr_err == exp_err && wr_pass == !exp_err, tag, {wr_err, wr_pass}, {exp_err, !exp_err});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    int st, blen;
    rst_n = 0; pwr_load = 1; pwr_bits = 4'b0101;
    cmd_valid = 0; cmd_op = 0; cmd_blk = 0; wr_valid = 0; wr_page = 0; wr_addr = 0;
    repeat (2) @(negedge clk);
    pwr_load = 0;
    repeat (2) @(negedge clk);
    // R7 reset state
    check(!busy && !cmd_ready && !wr_ready && !sts_valid && !wr_pass && !wr_err,
          "R7 reset outputs", {busy, cmd_ready, wr_ready}, 0);
    rst_n = 1;

    // R8 power-on pattern visible through status
    ask(0, 1, "R8 blk0"); ask(1, 0, "R8 blk1"); ask(2, 1, "R8 blk2"); ask(3, 0, "R8 blk3");

    // R1 address regions
    do_wr(0, 8'h10, 1, "R1 p0 low");
    do_wr(0, 8'h90, 0, "R1 p0 high");
    do_wr(1, 8'h7F, 1, "R1 p1 low");
    do_wr(1, 8'hFF, 0, "R1 p1 high");

    // R4 opcode 00 does nothing
    do_cmd(2'b00, 2'd1, st);
    check(!busy && !sts_valid, "R4 nop", busy, 0);

    // R3 clear all, R5 busy length
    do_cmd(2'b10, 2'd2, st);
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
    check(blen == TWB, "R5 busy length", blen, TWB);
    ask(0, 0, "R3 blk0"); ask(2, 0, "R3 blk2");

    // R2 set one block only
    do_cmd(2'b01, 2'd3, st);
    wait_idle();
    ask(3, 1, "R2 blk3"); ask(0, 0, "R2 blk0"); ask(1, 0, "R2 blk1"); ask(2, 0, "R2 blk2");

    // R6 command held during busy waits
    do_cmd(2'b01, 2'd1, st);
    do_cmd(2'b11, 2'd1, st);
    check(st >= TWB - 1, "R6 stall", st, TWB - 1);
    check(sts_prot == 1'b1, "R6 held read answered", sts_prot, 1);
    do_wr(0, 8'hA0, 1, "R6 write after wait");

    // R10 write races a set on its own block
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b01; cmd_blk = 2'd0;
    wr_valid = 1; wr_page = 0; wr_addr = 8'h05;
    @(negedge clk);
    cmd_valid = 0; wr_valid = 0;
    check(wr_pass == 1'b1 && wr_err == 1'b0, "R10 old state used", wr_pass, 1);
    wait_idle();
    do_wr(0, 8'h05, 1, "R10 now protected");

    // R7 reset mid-cycle keeps bits (now 1011), clears busy
    do_cmd(2'b01, 2'd2, st);
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!busy, "R7 busy cleared", busy, 0);
    rst_n = 1;
    ask(0, 1, "R7 blk0"); ask(1, 1, "R7 blk1"); ask(2, 1, "R7 blk2"); ask(3, 1, "R7 blk3");

    // R8 load during operation overrides a same-cycle clear
    @(negedge clk);
    pwr_load = 1; pwr_bits = 4'b0010; cmd_valid = 1; cmd_op = 2'b10;
    @(negedge clk);
    pwr_load = 0; cmd_valid = 0; cmd_op = 2'b00;
    wait_idle();
    ask(1, 1, "R8 override blk1"); ask(3, 0, "R8 override blk3");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule